// File: doc/BRIEF.md
# Four-Bit Arithmetic and Logic Unit with Status Flags

This block takes two unsigned 4-bit operands and a 3-bit operation select. It returns an 8-bit result and a 3-bit status vector. The unit can add, form the absolute difference (with a separate sign indication), apply bitwise AND, OR and XOR, invert either operand, and take the full unsigned product. The arithmetic core is purely combinational.

An output register stage can be chosen at build time. When it is present, the result and the status flags change one clock after the operands and the operation select are sampled. The register is cleared by a synchronous, active-high reset. When the stage is left out, the outputs follow the inputs in the same cycle and the clock and reset have no effect.

Flags are computed from the same evaluation that produces the result. They are never derived from the value the outputs held before. The operation select and both operands all steer the result, so a change on any one of them re-evaluates the whole unit.

Top module: `nib_alu`

## Requirements
- R1: With the output register present (the default), a clock edge that samples `rst` high sets `res` to 0 and `flags` to 3'b001. This holds whatever the operand and select inputs are in that cycle.
- R2: With the output register present, `res` and `flags` show the value computed from the inputs sampled at the previous clock edge. They hold that value until the next edge.
- R3: Select 3'b000 returns the sum of the zero-extended operands. The overflow flag equals bit 4 of that sum.
- R4: Select 3'b001 returns opa−opb with the sign flag at 0 when opa ≥ opb. Otherwise it returns opb−opa with the sign flag at 1.
- R5: Selects 3'b010, 3'b011 and 3'b100 return the bitwise AND, OR and XOR of the zero-extended operands.
- R6: Select 3'b101 returns the bitwise inverse of opa and select 3'b110 returns the bitwise inverse of opb. In both cases bits 7:4 of the result are 0.
- R7: Select 3'b111 returns the 8-bit unsigned product opa×opb.
- R8: The zero flag is 1 exactly when the 8-bit result is all zeros, for every select value.
- R9: The flag vector is laid out with the sign flag at bit 2, overflow at bit 1 and zero at bit 0. The sign flag is 0 for every select except 3'b001, and the overflow flag is 0 for every select except 3'b000.
- R10: When the select and both operands change in the same cycle, the next output reflects only the new combination, with no flag carried over from the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high clear of the output register |
| opa | input | 4 | First unsigned operand |
| opb | input | 4 | Second unsigned operand |
| opsel | input | 3 | Operation select |
| res | output | 8 | Operation result |
| flags | output | 3 | Status vector: sign, overflow, zero |

## Verification
Two things can land in the same cycle: a reset and a fresh set of operands, and a change of the select together with a change of both operands.

The bench provokes the first case by driving a full-scale multiply while reset is high. It judges the case by requiring the cleared value, and then the correct product one cycle after reset is released.

The second case is covered by the sweep, which presents a new select and a new operand pair on every clock. Each output is compared with the value computed for that cycle's inputs alone, so a stale overflow or sign flag from the previous operation shows up as a mismatch.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    // Operation select encoding; the numeric values are part of the interface.
    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADIF = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_NOTA = 3'b101,
        OP_NOTB = 3'b110,
        OP_MUL  = 3'b111
    } alu_op_e;

    localparam int OPSEL_W = 3;
    localparam int FLAG_W  = 3;

    // Packed MSB first: sgn is bit 2, ovf bit 1, zro bit 0.
    typedef struct packed {
        logic sgn;
        logic ovf;
        logic zro;
    } alu_flags_t;

    function automatic alu_flags_t flags_cleared();
        alu_flags_t f;
        f.sgn = 1'b0;
        f.ovf = 1'b0;
        f.zro = 1'b1;
        return f;
    endfunction

    function automatic alu_op_e decode_op(input logic [OPSEL_W-1:0] sel);
        return alu_op_e'(sel);
    endfunction

endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith #(
    parameter int OPW = 4
) (
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    output logic [2*OPW-1:0] sum_ext,
    output logic             carry,
    output logic [2*OPW-1:0] mag_ext,
    output logic             a_lt_b,
    output logic [2*OPW-1:0] prod
);
    localparam int RW  = 2*OPW;
    localparam int PAD = RW - OPW - 1;

    logic [OPW:0]   sum_w;
    logic [OPW-1:0] mag_w;
    logic [RW-1:0]  a_w;
    logic [RW-1:0]  b_w;

    assign a_w = {{OPW{1'b0}}, a};
    assign b_w = {{OPW{1'b0}}, b};

    // Sum with one extra bit so the carry comes from the same evaluation.
    assign sum_w   = {1'b0, a} + {1'b0, b};
    assign carry   = sum_w[OPW];
    assign sum_ext = {{PAD{1'b0}}, sum_w};

    // Absolute difference: subtract the smaller operand from the larger.
    assign a_lt_b  = (a < b);
    assign mag_w   = a_lt_b ? (b - a) : (a - b);
    assign mag_ext = {{OPW{1'b0}}, mag_w};

    // Full-width unsigned product.
    assign prod    = a_w * b_w;
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic #(
    parameter int OPW = 4
) (
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    output logic [2*OPW-1:0] and_o,
    output logic [2*OPW-1:0] or_o,
    output logic [2*OPW-1:0] xor_o,
    output logic [2*OPW-1:0] nota_o,
    output logic [2*OPW-1:0] notb_o
);
    localparam int RW = 2*OPW;

    for (genvar i = 0; i < RW; i++) begin : g_bit
        if (i < OPW) begin : g_low
            assign and_o[i]  = a[i] & b[i];
            assign or_o[i]   = a[i] | b[i];
            assign xor_o[i]  = a[i] ^ b[i];
            assign nota_o[i] = ~a[i];
            assign notb_o[i] = ~b[i];
        end else begin : g_high
            // Upper half: operands are zero-extended and complements are masked.
            assign and_o[i]  = 1'b0;
            assign or_o[i]   = 1'b0;
            assign xor_o[i]  = 1'b0;
            assign nota_o[i] = 1'b0;
            assign notb_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/nib_alu_flags.sv
module nib_alu_flags
    import nib_alu_pkg::*;
#(
    parameter int RW = 8
) (
    input  alu_op_e          op,
    input  logic [RW-1:0]    result,
    input  logic             carry,
    input  logic             a_lt_b,
    output alu_flags_t       f
);
    always_comb begin
        f     = '0;
        f.sgn = (op == OP_ADIF) && a_lt_b;
        f.ovf = (op == OP_ADD)  && carry;
        f.zro = ~|result;
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
#(
    parameter int OPW     = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OPW-1:0]      opa,
    input  logic [OPW-1:0]      opb,
    input  logic [OPSEL_W-1:0]  opsel,
    output logic [2*OPW-1:0]    res,
    output logic [FLAG_W-1:0]   flags
);
    localparam int RW = 2*OPW;

    alu_op_e      op;
    logic [RW-1:0] sum_ext, mag_ext, prod;
    logic [RW-1:0] and_v, or_v, xor_v, nota_v, notb_v;
    logic          carry, a_lt_b;
    logic [RW-1:0] res_c;
    alu_flags_t    flg_c;

    assign op = decode_op(opsel);

    nib_alu_arith #(.OPW(OPW)) arith_i (
        .a       (opa),
        .b       (opb),
        .sum_ext (sum_ext),
        .carry   (carry),
        .mag_ext (mag_ext),
        .a_lt_b  (a_lt_b),
        .prod    (prod)
    );

    nib_alu_logic #(.OPW(OPW)) logic_i (
        .a      (opa),
        .b      (opb),
        .and_o  (and_v),
        .or_o   (or_v),
        .xor_o  (xor_v),
        .nota_o (nota_v),
        .notb_o (notb_v)
    );

    always_comb begin
        res_c = '0;
        case (op)
            OP_ADD:  res_c = sum_ext;
            OP_ADIF: res_c = mag_ext;
            OP_AND:  res_c = and_v;
            OP_OR:   res_c = or_v;
            OP_XOR:  res_c = xor_v;
            OP_NOTA: res_c = nota_v;
            OP_NOTB: res_c = notb_v;
            OP_MUL:  res_c = prod;
            default: res_c = '0;
        endcase
    end

    nib_alu_flags #(.RW(RW)) flags_i (
        .op     (op),
        .result (res_c),
        .carry  (carry),
        .a_lt_b (a_lt_b),
        .f      (flg_c)
    );

    if (REG_OUT) begin : g_reg
        logic [RW-1:0] res_q;
        alu_flags_t    flg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                flg_q <= flags_cleared();
            end else begin
                res_q <= res_c;
                flg_q <= flg_c;
            end
        end

        assign res   = res_q;
        assign flags = flg_q;
    end else begin : g_comb
        assign res   = res_c;
        assign flags = flg_c;
    end
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk
    import nib_alu_pkg::*;
#(
    parameter int OPW     = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic [OPW-1:0]      opa,
    input logic [OPW-1:0]      opb,
    input logic [OPSEL_W-1:0]  opsel,
    input logic [2*OPW-1:0]    res,
    input logic [FLAG_W-1:0]   flags
);
    localparam int RW = 2*OPW;

    // Inputs aligned with the output latency.
    logic [OPW-1:0]     a_d, b_d;
    logic [OPSEL_W-1:0] op_d;
    logic               rst_d;

    if (REG_OUT) begin : g_lat
        always_ff @(posedge clk) begin
            a_d   <= opa;
            b_d   <= opb;
            op_d  <= opsel;
            rst_d <= rst;
        end
    end else begin : g_nolat
        assign a_d   = opa;
        assign b_d   = opb;
        assign op_d  = opsel;
        assign rst_d = rst;
    end

    // R8: zero flag tracks an all-zero result
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst || rst_d)
        flags[0] == (res == '0));

    // R9: overflow only for the add select
    assert_ovf_only_add_R9: assert property (@(posedge clk) disable iff (rst || rst_d)
        flags[1] |-> (op_d == OP_ADD));

    // R4: sign set only for a difference where opa < opb
    assert_sign_rule_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
        flags[2] |-> ((op_d == OP_ADIF) && (a_d < b_d)));

    // R6: complements keep the upper half clear
    assert_cmpl_upper_R6: assert property (@(posedge clk) disable iff (rst || rst_d)
        ((op_d == OP_NOTA) || (op_d == OP_NOTB)) |-> (res[RW-1:OPW] == '0));

    // R7: multiply yields the full product
    assert_product_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
        (op_d == OP_MUL) |-> (res == ({{OPW{1'b0}}, a_d} * {{OPW{1'b0}}, b_d})));

    // R3: add yields the zero-extended sum
    assert_sum_R3: assert property (@(posedge clk) disable iff (rst || rst_d)
        (op_d == OP_ADD) |-> (res == ({{OPW{1'b0}}, a_d} + {{OPW{1'b0}}, b_d})));
endmodule

bind nib_alu nib_alu_chk #(.OPW(OPW), .REG_OUT(REG_OUT)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .opa   (opa),
    .opb   (opb),
    .opsel (opsel),
    .res   (res),
    .flags (flags)
);

// File: tb/nib_alu_tb_top.sv
`timescale 1ns/1ps
module nib_alu_tb_top;
    localparam int OPW = 4;
    localparam int RW  = 2*OPW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [OPW-1:0] opa = '0;
    logic [OPW-1:0] opb = '0;
    logic [2:0]    opsel = 3'b000;
    logic [RW-1:0] res;
    logic [2:0]    flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nib_alu #(.OPW(OPW), .REG_OUT(1'b1)) dut_i (
        .clk   (clk),
        .rst   (rst),
        .opa   (opa),
        .opb   (opb),
        .opsel (opsel),
        .res   (res),
        .flags (flags)
    );

    task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2, 3, 4: return "R5";
            5, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Expected result and flags from the requirements alone.
    task automatic model(input int a, input int b, input int op,
                         output logic [RW-1:0] r, output logic [2:0] f);
        int v;
        bit s, o;
        s = 1'b0;
        o = 1'b0;
        case (op)
            0: begin v = a + b; o = (v > 15); end
            1: begin if (a >= b) v = a - b; else begin v = b - a; s = 1'b1; end end
            2: v = a & b;
            3: v = a | b;
            4: v = a ^ b;
            5: v = (~a) & 15;
            6: v = (~b) & 15;
            default: v = a * b;
        endcase
        r = RW'(v);
        f = {s, o, (v == 0)};
    endtask

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [RW-1:0] er;
        logic [2:0]    ef;
        logic [RW-1:0] pr;
        logic [2:0]    pf;
        string         preq;
        bit            have;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset res", res, '0);
        check("R1 reset flags", {5'b0, flags}, 8'h01);

        // Back-to-back exhaustive sweep; every cycle changes select and operands (R10).
        @(negedge clk);
        rst  = 1'b0;
        have = 1'b0;
        pr   = '0;
        pf   = '0;
        preq = "";
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    if (have) begin
                        check({preq, " R10 res"}, res, pr);
                        check({preq, " R8 R9 flags"}, {5'b0, flags}, {5'b0, pf});
                    end
                    opa   = OPW'(a);
                    opb   = OPW'(b);
                    opsel = 3'(op);
                    model(a, b, op, er, ef);
                    pr   = er;
                    pf   = ef;
                    preq = req_of(op);
                    have = 1'b1;
                    @(negedge clk);
                end
            end
        end
        check({preq, " R10 res"}, res, pr);
        check({preq, " R8 R9 flags"}, {5'b0, flags}, {5'b0, pf});

        // R2: output holds until the next edge, then updates.
        opa = 4'd3; opb = 4'd4; opsel = 3'b000;
        #1;
        check("R2 hold res", res, pr);
        @(negedge clk);
        check("R2 update res", res, 8'd7);
        check("R2 update flags", {5'b0, flags}, 8'h00);

        // R3 boundary: 15+1 sets overflow, result 16
        opa = 4'd15; opb = 4'd1; opsel = 3'b000;
        @(negedge clk);
        check("R3 carry res", res, 8'd16);
        check("R3 carry flags", {5'b0, flags}, 8'h02);

        // R1: reset wins over a full-scale multiply in the same cycle
        rst = 1'b1; opa = 4'd15; opb = 4'd15; opsel = 3'b111;
        @(negedge clk);
        check("R1 priority res", res, '0);
        check("R1 priority flags", {5'b0, flags}, 8'h01);
        rst = 1'b0;
        @(negedge clk);
        check("R7 after reset res", res, 8'd225);
        check("R7 after reset flags", {5'b0, flags}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule